// File: doc/BRIEF.md
# Packed Sub-Word Multiply-Add Unit

This unit executes one integer instruction of a shader-style processor. It receives a 64-bit instruction word and three 32-bit register values. From the first value it takes a byte or a 16-bit half. The second factor is either a byte or half of the second register or a 16-bit immediate carried in the instruction. It forms first × second + third at double width. It can then shift the sum right and clamp it to the 32-bit range. The 32-bit result and two condition flags are registered, so they appear one clock after issue.

Each factor has its own selector: a chunk flag plus a 2-bit code. When the chunk flag is clear the code is a byte lane. When it is set, the code picks the low half, the high half, the full 32-bit word or a reserved value. The full-word form is not implemented. It writes zero and raises an unsupported indication. The reserved code also writes zero. Signedness is set per factor, and the sum is treated as signed as soon as either factor is signed.

Top module: `subword_mad_unit`

## Requirements
- R1: An instruction issues when `valid_i` is high and `instr_i[63:56]` equals 8'h5F. `valid_o` is high exactly in the cycle after an issue.
- R2: With a clear chunk flag (bit 38 for the first factor, bit 30 for the second), the factor is byte number `code` of its register, where code is bits 37:36 or bits 29:28 and byte 0 is bits 7:0.
- R3: With the chunk flag set, code 0 selects bits 15:0 and code 1 selects bits 31:16.
- R4: Bit 48 makes the first factor signed and bit 49 makes the second signed. A signed factor is sign-extended from its selected width. If either bit is set, the third operand is sign-extended and any right shift is arithmetic. Otherwise all three are zero-extended.
- R5: When bit 50 is clear, the second factor is the immediate in bits 35:20, sign-extended if bit 49 is set and zero-extended otherwise. The second factor's selector code is then ignored.
- R6: Bits 52:51 select the right shift of the sum: 1 shifts by 7, 2 shifts by 15, and 0 or 3 applies no shift.
- R7: When bit 55 is set, a signed result is clamped to [-2^31, 2^31-1] and an unsigned one to [0, 2^32-1].
- R8: When bit 55 is clear, the result is the low 32 bits of the shifted sum.
- R9: Chunk flag set with code 3 on the first factor, or on the second factor when it comes from its register, writes a zero result.
- R10: Chunk flag set with code 2 on such a factor writes a zero result and sets `unsupported_o`. `unsupported_o` is clear for every other issued instruction.
- R11: `zero_o` and `sign_o` take "result equals zero" and "result bit 31" of the written result, but only for an issue with bit 47 set. Otherwise they hold.
- R12: Reset clears all outputs. `result_o` and `unsupported_o` change only on an issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 64 | Instruction word |
| opa_i | input | 32 | First factor register |
| opb_i | input | 32 | Second factor register |
| opc_i | input | 32 | Addend register |
| valid_o | output | 1 | Result written this cycle |
| result_o | output | 32 | Destination value |
| unsupported_o | output | 1 | Full-word mode requested |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |

## Verification
A fault in selection, extension, shifting or clamping shows up in `result_o` in the cycle right after the faulty instruction. No state carries between instructions except the held result and flags. A fault in the flag enable stays hidden until a later instruction without bit 47. The flags then differ from the last flag-setting result, so the bench issues flag-setting and non-flag-setting instructions back to back. A reference model run over a random sweep covers the many combinations of selector, sign, shift and clamp that the table does not list.

// File: rtl/smad_pkg.sv
package smad_pkg;

    localparam int INSTR_W  = 64;
    localparam int IMM_W    = 16;
    localparam int OPC_LSB  = 56;
    localparam logic [7:0] OPCODE = 8'h5F;

    localparam int BIT_SAT    = 55;
    localparam int BIT_SHR_LO = 51;
    localparam int BIT_BREG   = 50;
    localparam int BIT_BSGN   = 49;
    localparam int BIT_ASGN   = 48;
    localparam int BIT_CC     = 47;
    localparam int BIT_ACHK   = 38;
    localparam int BIT_ACODE  = 36;
    localparam int BIT_IMM    = 20;
    localparam int BIT_BCHK   = 30;
    localparam int BIT_BCODE  = 28;

    localparam int SHIFT_SHORT = 7;
    localparam int SHIFT_LONG  = 15;

    typedef enum logic [1:0] {
        SH_OFF     = 2'd0,
        SH_SHORT   = 2'd1,
        SH_LONG    = 2'd2,
        SH_OFF_ALT = 2'd3
    } shift_e;

    typedef enum logic [1:0] {
        SEL_LOW  = 2'd0,
        SEL_HIGH = 2'd1,
        SEL_WIDE = 2'd2,
        SEL_RSVD = 2'd3
    } half_code_e;

    typedef struct packed {
        logic             hit;
        logic             a_signed;
        logic             b_signed;
        logic             b_from_reg;
        logic             cc_en;
        logic             sat_en;
        shift_e           shift;
        logic             a_chunk;
        logic [1:0]       a_code;
        logic             b_chunk;
        logic [1:0]       b_code;
        logic [IMM_W-1:0] imm;
    } ctrl_t;

    function automatic logic opcode_hit(input logic [INSTR_W-1:0] w);
        return w[INSTR_W-1:OPC_LSB] == OPCODE;
    endfunction

endpackage

// File: rtl/smad_decode.sv
module smad_decode
    import smad_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output ctrl_t              ctrl_o
);
    logic unused_bits;
    assign unused_bits = ^{instr_i[54:53], instr_i[46:39], instr_i[19:0]};

    always_comb begin
        ctrl_o.hit        = opcode_hit(instr_i);
        ctrl_o.a_signed   = instr_i[BIT_ASGN];
        ctrl_o.b_signed   = instr_i[BIT_BSGN];
        ctrl_o.b_from_reg = instr_i[BIT_BREG];
        ctrl_o.cc_en      = instr_i[BIT_CC];
        ctrl_o.sat_en     = instr_i[BIT_SAT];
        ctrl_o.shift      = shift_e'(instr_i[BIT_SHR_LO +: 2]);
        ctrl_o.a_chunk    = instr_i[BIT_ACHK];
        ctrl_o.a_code     = instr_i[BIT_ACODE +: 2];
        ctrl_o.b_chunk    = instr_i[BIT_BCHK];
        ctrl_o.b_code     = instr_i[BIT_BCODE +: 2];
        ctrl_o.imm        = instr_i[BIT_IMM +: IMM_W];
    end
endmodule

// File: rtl/smad_operand_sel.sv
module smad_operand_sel
    import smad_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]  op_i,
    input  logic               chunk_i,
    input  logic [1:0]         code_i,
    input  logic               signed_i,
    output logic signed [DATA_W:0] val_o,
    output logic               wide_o,
    output logic               rsvd_o
);
    localparam int LANES  = DATA_W / 8;
    localparam int HALF_W = DATA_W / 2;

    logic [7:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = op_i[g*8 +: 8];
    end

    logic [7:0]        byte_v;
    logic [HALF_W-1:0] half_v;

    always_comb begin
        byte_v = lane[code_i];
        half_v = (code_i == SEL_HIGH) ? op_i[DATA_W-1 -: HALF_W] : op_i[HALF_W-1:0];
        if (!chunk_i)
            val_o = {{(DATA_W+1-8){signed_i & byte_v[7]}}, byte_v};
        else
            val_o = {{(DATA_W+1-HALF_W){signed_i & half_v[HALF_W-1]}}, half_v};
        wide_o = chunk_i && (code_i == SEL_WIDE);
        rsvd_o = chunk_i && (code_i == SEL_RSVD);
    end
endmodule

// File: rtl/smad_arith.sv
module smad_arith
    import smad_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic signed [DATA_W:0] a_i,
    input  logic signed [DATA_W:0] b_i,
    input  logic [DATA_W-1:0]      c_i,
    input  logic                   res_signed_i,
    input  shift_e                 shift_i,
    input  logic                   sat_i,
    output logic [DATA_W-1:0]      res_o
);
    localparam int ACC_W = 2*DATA_W + 2;

    logic signed [ACC_W-1:0] a_x, b_x, c_x, prod, sum, shifted;
    logic signed [ACC_W-1:0] max_s, min_s, max_u;

    always_comb begin
        a_x  = {{(ACC_W-DATA_W-1){a_i[DATA_W]}}, a_i};
        b_x  = {{(ACC_W-DATA_W-1){b_i[DATA_W]}}, b_i};
        c_x  = {{(ACC_W-DATA_W){res_signed_i & c_i[DATA_W-1]}}, c_i};
        prod = a_x * b_x;
        sum  = prod + c_x;

        unique case (shift_i)
            SH_SHORT: shifted = res_signed_i ? (sum >>> SHIFT_SHORT) : (sum >> SHIFT_SHORT);
            SH_LONG:  shifted = res_signed_i ? (sum >>> SHIFT_LONG)  : (sum >> SHIFT_LONG);
            default:  shifted = sum;
        endcase

        max_s = '0; max_s[DATA_W-2:0] = '1;
        min_s = '1; min_s[DATA_W-2:0] = '0;
        max_u = '0; max_u[DATA_W-1:0] = '1;

        res_o = shifted[DATA_W-1:0];
        if (sat_i) begin
            if (res_signed_i) begin
                if (shifted > max_s)      res_o = max_s[DATA_W-1:0];
                else if (shifted < min_s) res_o = min_s[DATA_W-1:0];
            end else begin
                if (shifted > max_u)      res_o = max_u[DATA_W-1:0];
                else if (shifted < 0)     res_o = '0;
            end
        end
    end
endmodule

// File: rtl/subword_mad_unit.sv
module subword_mad_unit
    import smad_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_i,
    input  logic [63:0]        instr_i,
    input  logic [DATA_W-1:0]  opa_i,
    input  logic [DATA_W-1:0]  opb_i,
    input  logic [DATA_W-1:0]  opc_i,
    output logic               valid_o,
    output logic [DATA_W-1:0]  result_o,
    output logic               unsupported_o,
    output logic               zero_o,
    output logic               sign_o
);
    ctrl_t ctrl;

    smad_decode u_dec (.instr_i(instr_i), .ctrl_o(ctrl));

    logic signed [DATA_W:0] a_val, b_reg_val, b_val;
    logic a_wide, a_rsvd, b_wide, b_rsvd;

    smad_operand_sel #(.DATA_W(DATA_W)) u_sel_a (
        .op_i(opa_i), .chunk_i(ctrl.a_chunk), .code_i(ctrl.a_code),
        .signed_i(ctrl.a_signed), .val_o(a_val), .wide_o(a_wide), .rsvd_o(a_rsvd)
    );

    smad_operand_sel #(.DATA_W(DATA_W)) u_sel_b (
        .op_i(opb_i), .chunk_i(ctrl.b_chunk), .code_i(ctrl.b_code),
        .signed_i(ctrl.b_signed), .val_o(b_reg_val), .wide_o(b_wide), .rsvd_o(b_rsvd)
    );

    logic b_wide_eff, b_rsvd_eff, res_signed, force_zero, unsup_now;
    logic [DATA_W-1:0] arith_res, final_res;

    always_comb begin
        b_val = ctrl.b_from_reg ? b_reg_val
              : {{(DATA_W+1-IMM_W){ctrl.b_signed & ctrl.imm[IMM_W-1]}}, ctrl.imm};
        b_wide_eff = ctrl.b_from_reg & b_wide;
        b_rsvd_eff = ctrl.b_from_reg & b_rsvd;
        res_signed = ctrl.a_signed | ctrl.b_signed;
        unsup_now  = a_wide | b_wide_eff;
        force_zero = unsup_now | a_rsvd | b_rsvd_eff;
    end

    smad_arith #(.DATA_W(DATA_W)) u_arith (
        .a_i(a_val), .b_i(b_val), .c_i(opc_i), .res_signed_i(res_signed),
        .shift_i(ctrl.shift), .sat_i(ctrl.sat_en), .res_o(arith_res)
    );

    assign final_res = force_zero ? '0 : arith_res;

    logic issue;
    assign issue = valid_i & ctrl.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o       <= 1'b0;
            result_o      <= '0;
            unsupported_o <= 1'b0;
            zero_o        <= 1'b0;
            sign_o        <= 1'b0;
        end else begin
            valid_o <= issue;
            if (issue) begin
                result_o      <= final_res;
                unsupported_o <= unsup_now;
                if (ctrl.cc_en) begin
                    zero_o <= (final_res == '0);
                    sign_o <= final_res[DATA_W-1];
                end
            end
        end
    end
endmodule

// File: rtl/smad_checker.sv
module smad_checker
    import smad_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [63:0]       instr_i,
    input logic              valid_o,
    input logic [DATA_W-1:0] result_o,
    input logic              unsupported_o,
    input logic              zero_o,
    input logic              sign_o
);
    logic hit_in;
    assign hit_in = valid_i && (instr_i[63:56] == OPCODE);

    a_r1_valid_follows_issue: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (valid_o == $past(hit_in)));

    a_r10_unsupported_zero: assert property (@(posedge clk) disable iff (rst)
        unsupported_o |-> (result_o == '0));

    a_r11_flags_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hit_in && instr_i[BIT_CC])) |-> $stable({zero_o, sign_o}));

    a_r11_flags_match: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hit_in && instr_i[BIT_CC]))
            |-> (zero_o == (result_o == '0)) && (sign_o == result_o[DATA_W-1]));

    a_r12_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hit_in)) |-> ($stable(result_o) && $stable(unsupported_o)));
endmodule

bind subword_mad_unit smad_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
    .valid_o(valid_o), .result_o(result_o), .unsupported_o(unsupported_o),
    .zero_o(zero_o), .sign_o(sign_o)
);

// File: tb/subword_mad_unit_tb.sv
module subword_mad_unit_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [63:0] instr_i = '0;
    logic [31:0] opa_i = '0, opb_i = '0, opc_i = '0;
    logic        valid_o, unsupported_o, zero_o, sign_o;
    logic [31:0] result_o;

    int tests = 0;
    int fails = 0;

    always #(CLK_P/2) clk = ~clk;

    subword_mad_unit u_dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
        .opa_i(opa_i), .opb_i(opb_i), .opc_i(opc_i), .valid_o(valid_o),
        .result_o(result_o), .unsupported_o(unsupported_o),
        .zero_o(zero_o), .sign_o(sign_o)
    );

    function automatic logic [63:0] mk(input logic sa, input logic sb, input logic regb,
                                       input logic cc, input logic sat, input logic [1:0] shr,
                                       input logic cha, input logic [1:0] ta,
                                       input logic chb, input logic [1:0] tb,
                                       input logic [15:0] imm);
        logic [63:0] v;
        v = '0;
        v[63:56] = 8'h5F;
        v[55] = sat; v[52:51] = shr; v[50] = regb; v[49] = sb; v[48] = sa; v[47] = cc;
        v[38] = cha; v[37:36] = ta;
        if (regb) begin v[30] = chb; v[29:28] = tb; end
        else v[35:20] = imm;
        return v;
    endfunction

    typedef struct packed {
        logic [7:0]  tag;
        logic [63:0] ins;
        logic [31:0] a, b, c, exp;
        logic        un;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{8'd2,  mk(0,0,1,0,0,2'd0, 0,2'd1, 0,2'd0, 16'h0),    32'h11223344, 32'h000000F0, 32'd5,        32'h00002FD5, 1'b0}, // R2
        '{8'd3,  mk(0,0,1,0,0,2'd0, 1,2'd1, 1,2'd0, 16'h0),    32'hABCD1234, 32'h00020003, 32'h10,       32'h00020377, 1'b0}, // R3
        '{8'd4,  mk(1,0,0,0,0,2'd0, 0,2'd0, 0,2'd0, 16'h0005), 32'h000000FF, 32'h0,        32'h0,        32'hFFFFFFFB, 1'b0}, // R4
        '{8'd5,  mk(0,1,0,0,0,2'd0, 0,2'd0, 0,2'd0, 16'hFFFE), 32'h00000010, 32'h0,        32'd100,      32'h00000044, 1'b0}, // R5
        '{8'd5,  mk(0,0,0,0,0,2'd0, 0,2'd0, 0,2'd0, 16'hFFFE), 32'h00000010, 32'h0,        32'h0,        32'h000FFFE0, 1'b0}, // R5
        '{8'd6,  mk(0,0,0,0,0,2'd1, 1,2'd0, 0,2'd0, 16'h0100), 32'h0000FFFF, 32'h0,        32'h0,        32'h0001FFFE, 1'b0}, // R6
        '{8'd6,  mk(1,0,0,0,0,2'd2, 1,2'd0, 0,2'd0, 16'h0003), 32'h00008000, 32'h0,        32'h0,        32'hFFFFFFFD, 1'b0}, // R6
        '{8'd6,  mk(0,0,0,0,0,2'd3, 0,2'd0, 0,2'd0, 16'h0002), 32'h00000007, 32'h0,        32'd1,        32'h0000000F, 1'b0}, // R6
        '{8'd7,  mk(0,0,0,0,1,2'd0, 1,2'd0, 0,2'd0, 16'hFFFF), 32'h0000FFFF, 32'h0,        32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0}, // R7
        '{8'd8,  mk(0,0,0,0,0,2'd0, 1,2'd0, 0,2'd0, 16'hFFFF), 32'h0000FFFF, 32'h0,        32'hFFFFFFFF, 32'hFFFE0000, 1'b0}, // R8
        '{8'd7,  mk(1,1,0,0,1,2'd0, 1,2'd0, 0,2'd0, 16'h0001), 32'h00000001, 32'h0,        32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0}, // R7
        '{8'd7,  mk(1,0,0,0,1,2'd0, 0,2'd0, 0,2'd0, 16'h0001), 32'h000000FF, 32'h0,        32'h80000000, 32'h80000000, 1'b0}, // R7
        '{8'd8,  mk(1,0,0,0,0,2'd0, 0,2'd0, 0,2'd0, 16'h0001), 32'h000000FF, 32'h0,        32'h80000000, 32'h7FFFFFFF, 1'b0}, // R8
        '{8'd9,  mk(0,0,1,0,0,2'd0, 1,2'd3, 0,2'd0, 16'h0),    32'd5,        32'd5,        32'd5,        32'h0,        1'b0}, // R9
        '{8'd9,  mk(0,0,1,0,0,2'd0, 0,2'd0, 1,2'd3, 16'h0),    32'd5,        32'd5,        32'd5,        32'h0,        1'b0}, // R9
        '{8'd10, mk(0,0,1,0,0,2'd0, 1,2'd2, 0,2'd0, 16'h0),    32'd5,        32'd5,        32'd5,        32'h0,        1'b1}, // R10
        '{8'd5,  mk(0,0,0,0,0,2'd0, 0,2'd0, 0,2'd0, 16'h0700), 32'h00000002, 32'h0,        32'd1,        32'h00000E01, 1'b0}, // R5
        '{8'd4,  mk(0,1,1,0,0,2'd0, 0,2'd0, 1,2'd1, 16'h0),    32'h00000003, 32'hFFFE0000, 32'h10,       32'h0000000A, 1'b0}, // R4
        '{8'd10, mk(0,0,1,0,0,2'd0, 0,2'd0, 1,2'd2, 16'h0),    32'd5,        32'd5,        32'd5,        32'h0,        1'b1}, // R10
        '{8'd4,  mk(0,1,0,0,0,2'd1, 0,2'd0, 0,2'd0, 16'h0001), 32'h00000001, 32'h0,        32'hFFFFFFF0, 32'hFFFFFFFF, 1'b0}  // R4
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [63:0] ins,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        @(negedge clk);
        valid_i = v; instr_i = ins; opa_i = a; opb_i = b; opc_i = c;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    function automatic longint pick(input logic [31:0] v, input logic chunk,
                                    input logic [1:0] code, input logic sgn);
        longint x;
        if (!chunk) begin
            x = longint'((v >> (code * 8)) & 32'hFF);
            if (sgn && x > 127) x -= 256;
        end else begin
            x = code[0] ? longint'(v >> 16) : longint'(v & 32'hFFFF);
            if (sgn && x > 32767) x -= 65536;
        end
        return x;
    endfunction

    task automatic model(input logic [63:0] ins, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, output logic [31:0] r, output logic un);
        logic sg, rsv, wide;
        longint av, bv, cv, s;
        sg   = ins[48] | ins[49];
        rsv  = ins[38] && ins[37:36] == 2'd3;
        wide = ins[38] && ins[37:36] == 2'd2;
        if (ins[50]) begin
            rsv  = rsv  || (ins[30] && ins[29:28] == 2'd3);
            wide = wide || (ins[30] && ins[29:28] == 2'd2);
        end
        av = pick(a, ins[38], ins[37:36], ins[48]);
        if (ins[50]) bv = pick(b, ins[30], ins[29:28], ins[49]);
        else bv = ins[49] ? longint'($signed(ins[35:20])) : longint'(ins[35:20]);
        cv = sg ? longint'($signed(c)) : longint'(c);
        s = av * bv + cv;
        if (ins[52:51] == 2'd1) s = s >>> 7;
        else if (ins[52:51] == 2'd2) s = s >>> 15;
        if (ins[55]) begin
            if (sg) begin
                if (s > 64'sh7FFFFFFF) s = 64'sh7FFFFFFF;
                else if (s < -64'sh80000000) s = -64'sh80000000;
            end else begin
                if (s > 64'shFFFFFFFF) s = 64'shFFFFFFFF;
                else if (s < 0) s = 0;
            end
        end
        r  = (rsv || wide) ? 32'h0 : s[31:0];
        un = wide;
    endtask

    initial begin
        #(CLK_P * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] mr, held;
        logic        mu;
        logic [63:0] ri;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 reset result", result_o, 32'h0);
        chk("R12 reset valid/unsup/flags", {28'h0, valid_o, unsupported_o, zero_o, sign_o}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(1'b1, VECS[i].ins, VECS[i].a, VECS[i].b, VECS[i].c);
            chk($sformatf("R%0d vec%0d result", VECS[i].tag, i), result_o, VECS[i].exp);
            chk($sformatf("R%0d vec%0d unsupported", VECS[i].tag, i), {31'h0, unsupported_o}, {31'h0, VECS[i].un});
            chk($sformatf("R1 vec%0d valid", i), {31'h0, valid_o}, 32'h1);
        end

        // R1: valid_o drops the cycle after; R1 wrong opcode does not issue
        issue(1'b1, mk(0,0,0,0,0,2'd0, 0,2'd0, 0,2'd0, 16'h0003), 32'd2, 32'd0, 32'd0);
        held = result_o;
        chk("R1 issue result", held, 32'd6);
        @(negedge clk);
        chk("R1 valid low after idle", {31'h0, valid_o}, 32'h0);
        ri = mk(0,0,0,0,0,2'd0, 0,2'd0, 0,2'd0, 16'h0009);
        ri[63:56] = 8'h5E;
        issue(1'b1, ri, 32'd2, 32'd0, 32'd0);
        chk("R1 wrong opcode valid", {31'h0, valid_o}, 32'h0);
        chk("R12 wrong opcode result held", result_o, held);
        // R12: valid low leaves result alone
        issue(1'b0, mk(0,0,0,0,0,2'd0, 0,2'd0, 0,2'd0, 16'h0009), 32'd2, 32'd0, 32'd0);
        chk("R12 idle valid", {31'h0, valid_o}, 32'h0);
        chk("R12 idle result held", result_o, held);

        // R11: flags
        issue(1'b1, mk(0,0,1,1,0,2'd0, 1,2'd3, 0,2'd0, 16'h0), 32'd7, 32'd7, 32'd7);
        chk("R11 zero result flags", {30'h0, zero_o, sign_o}, 32'h2);
        issue(1'b1, mk(1,0,0,1,0,2'd0, 0,2'd0, 0,2'd0, 16'h0001), 32'hFF, 32'd0, 32'd0);
        chk("R11 negative flags", {30'h0, zero_o, sign_o}, 32'h1);
        issue(1'b1, mk(0,0,0,0,0,2'd0, 0,2'd0, 0,2'd0, 16'h0000), 32'd0, 32'd0, 32'd0);
        chk("R11 result without cc", result_o, 32'h0);
        chk("R11 flags held without cc", {30'h0, zero_o, sign_o}, 32'h1);
        issue(1'b1, mk(0,0,0,1,0,2'd0, 0,2'd0, 0,2'd0, 16'h0004), 32'd3, 32'd0, 32'd0);
        chk("R11 positive flags", {30'h0, zero_o, sign_o}, 32'h0);

        // random sweep against the reference model (R2..R10 combinations)
        for (int k = 0; k < 400; k++) begin
            ri = {$urandom, $urandom};
            ri[63:56] = 8'h5F;
            opa_i = $urandom;
            model(ri, opa_i, $urandom, $urandom, mr, mu);
        end
        for (int k = 0; k < 400; k++) begin
            logic [31:0] ra, rb, rc;
            ri = {$urandom, $urandom};
            ri[63:56] = 8'h5F;
            ra = $urandom; rb = $urandom; rc = $urandom;
            if (k % 4 == 0) begin ra = ra | 32'h80808080; rc = rc | 32'h80000000; end
            model(ri, ra, rb, rc, mr, mu);
            issue(1'b1, ri, ra, rb, rc);
            chk($sformatf("R7 sweep%0d instr=%h result", k, ri), result_o, mr);
            chk($sformatf("R10 sweep%0d unsupported", k), {31'h0, unsupported_o}, {31'h0, mu});
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule